// File: doc/BRIEF.md
# SPI Interrupt and Status Generator

This block drives the two interrupt lines of an SPI port, one for data and one for errors, and keeps the sticky error status that software reads and clears. A two-bit transfer mode input picks how the data line behaves. In the two core modes it tells the processor that a receive word can be read (mode 00) or that the transmit buffer can take a word (mode 01). In the two DMA modes it acts as a DMA request: mode 10 asks for a read when the DMA FIFO holds data, and mode 11 asks for a write when the FIFO has room.

The block also detects the error events. A transmit underflow is a word shift starting while the transmit buffer is empty. A receive overflow is a word finishing while the receive buffer is still full. A mode fault counts only when the port is an enabled master. A transmit collision is flagged by the shift logic. Each event sets a sticky status bit, whatever the mode. Only some of those bits feed the error line: the fault bit always does, the underflow bit only in mode 11, and the overflow bit only in mode 10. The collision bit never does.

Every output is registered. An input seen at one clock edge shows up at the ports right after the next edge.

Top module: `spi_irq_status_gen`

## Requirements
- R1: While reset is asserted (rst_n low), data_irq, err_irq and all four status bits read 0.
- R2: One cycle after inputs are sampled with port_en high, data_irq equals the condition chosen by xfer_mode: 00 selects rx_buf_full, 01 selects tx_buf_empty, 10 selects dma_fifo_rd_rdy and 11 selects dma_fifo_wr_rdy.
- R3: When port_en is sampled low, data_irq is 0 in the following cycle, in every mode.
- R4: A mode_fault_det pulse sampled while is_master and port_en are both high sets status bit 0 and raises err_irq, in every mode.
- R5: A mode_fault_det pulse sampled while is_master is low or port_en is low leaves status bit 0 unchanged.
- R6: With port_en high, xfer_start together with tx_buf_empty sets status bit 1 (underflow), and xfer_done together with rx_buf_full sets status bit 2 (overflow). Both hold in every mode.
- R7: Status bit 1 contributes to err_irq only while xfer_mode is 11, and status bit 2 only while xfer_mode is 10. While xfer_mode is 00 or 01, err_irq equals status bit 0.
- R8: A tx_collide_det pulse sampled with port_en high sets status bit 3. This bit never raises err_irq.
- R9: A write (stat_wr_en high) clears each status bit whose stat_wr_data bit is 1 and leaves the bits written with 0 unchanged. When a set and a clear reach the same bit in the same cycle, the set wins.
- R10: err_irq is the OR of the status bits enabled for the current mode. It stays high until software clears every contributing bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| port_en | input | 1 | Port enable |
| is_master | input | 1 | 1 = master operation, 0 = slave |
| xfer_mode | input | 2 | Transfer mode: 00 core rx, 01 core tx, 10 DMA read, 11 DMA write |
| mode_fault_det | input | 1 | Mode-fault detect from the pin logic |
| tx_buf_empty | input | 1 | Transmit data buffer is empty |
| rx_buf_full | input | 1 | Receive data buffer holds an unread word |
| dma_fifo_rd_rdy | input | 1 | DMA FIFO holds data to be read |
| dma_fifo_wr_rdy | input | 1 | DMA FIFO can accept a write |
| xfer_start | input | 1 | Shifter is loading a new word this cycle |
| xfer_done | input | 1 | Shifter finished receiving a word this cycle |
| tx_collide_det | input | 1 | Transmit buffer written during a load (collision) |
| stat_wr_en | input | 1 | Status write strobe |
| stat_wr_data | input | 4 | Write-one-to-clear mask for the status bits |
| data_irq | output | 1 | Data interrupt or DMA request |
| err_irq | output | 1 | Error interrupt |
| status | output | 4 | Sticky status: [0] fault, [1] underflow, [2] overflow, [3] collision |

## Verification
A wrong sticky bit shows up on the status port one cycle after the event that should, or should not, have set it. A bit that drops without a clear write, or one that a zero write disturbs, is visible on the next cycle. A fault in the per-mode error mask appears on err_irq in the first cycle after the mode changes while a bit is set, even though status stays the same. A wrong data source choice shows on data_irq one cycle after the inputs that tell the four conditions apart.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;
    localparam int MODE_W  = 2;
    localparam int STAT_W  = 4;
    localparam int ST_FAULT = 0;
    localparam int ST_UNDER = 1;
    localparam int ST_OVER  = 2;
    localparam int ST_COLL  = 3;

    typedef enum logic [MODE_W-1:0] {
        XM_CORE_RX = 2'b00,
        XM_CORE_TX = 2'b01,
        XM_DMA_RD  = 2'b10,
        XM_DMA_WR  = 2'b11
    } xfer_mode_e;

    typedef logic [STAT_W-1:0] stat_t;

    typedef struct packed {
        logic data_irq;
        logic err_irq;
    } irq_t;
endpackage

// File: rtl/spi_err_detect.sv
module spi_err_detect
    import spi_irq_pkg::*;
(
    input  logic  port_en,
    input  logic  is_master,
    input  logic  mode_fault_det,
    input  logic  xfer_start,
    input  logic  tx_buf_empty,
    input  logic  xfer_done,
    input  logic  rx_buf_full,
    input  logic  tx_collide_det,
    output stat_t set_vec
);
    always_comb begin
        set_vec           = '0;
        set_vec[ST_FAULT] = port_en & is_master & mode_fault_det;
        set_vec[ST_UNDER] = port_en & xfer_start & tx_buf_empty;
        set_vec[ST_OVER]  = port_en & xfer_done & rx_buf_full;
        set_vec[ST_COLL]  = port_en & tx_collide_det;
    end
endmodule

// File: rtl/spi_stat_regs.sv
module spi_stat_regs
    import spi_irq_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  stat_t set_vec,
    input  logic  wr_en,
    input  stat_t wr_data,
    output stat_t stat_d_o,
    output stat_t stat_q_o
);
    stat_t clr_vec;
    stat_t stat_d, stat_q;

    for (genvar gi = 0; gi < STAT_W; gi++) begin : g_bit
        // set beats clear on the same cycle
        assign clr_vec[gi] = wr_en & wr_data[gi] & ~set_vec[gi];
    end

    always_comb begin
        stat_d = (stat_q & ~clr_vec) | set_vec;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= stat_d;
    end

    assign stat_d_o = stat_d;
    assign stat_q_o = stat_q;
endmodule

// File: rtl/spi_irq_route.sv
module spi_irq_route
    import spi_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              port_en,
    input  logic [MODE_W-1:0] xfer_mode,
    input  logic              tx_buf_empty,
    input  logic              rx_buf_full,
    input  logic              fifo_rd_rdy,
    input  logic              fifo_wr_rdy,
    input  stat_t             stat_next,
    output logic              data_irq,
    output logic              err_irq
);
    irq_t       irq_d, irq_q;
    xfer_mode_e mode;
    stat_t      err_mask;

    always_comb begin
        mode = xfer_mode_e'(xfer_mode);
        err_mask           = '0;
        err_mask[ST_FAULT] = 1'b1;
        err_mask[ST_UNDER] = (mode == XM_DMA_WR);
        err_mask[ST_OVER]  = (mode == XM_DMA_RD);

        irq_d = '0;
        unique case (mode)
            XM_CORE_RX: irq_d.data_irq = rx_buf_full;
            XM_CORE_TX: irq_d.data_irq = tx_buf_empty;
            XM_DMA_RD:  irq_d.data_irq = fifo_rd_rdy;
            XM_DMA_WR:  irq_d.data_irq = fifo_wr_rdy;
            default:    irq_d.data_irq = 1'b0;
        endcase
        irq_d.data_irq = irq_d.data_irq & port_en;
        irq_d.err_irq  = |(stat_next & err_mask);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= '0;
        else        irq_q <= irq_d;
    end

    assign data_irq = irq_q.data_irq;
    assign err_irq  = irq_q.err_irq;
endmodule

// File: rtl/spi_irq_status_gen.sv
module spi_irq_status_gen
    import spi_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              port_en,
    input  logic              is_master,
    input  logic [MODE_W-1:0] xfer_mode,
    input  logic              mode_fault_det,
    input  logic              tx_buf_empty,
    input  logic              rx_buf_full,
    input  logic              dma_fifo_rd_rdy,
    input  logic              dma_fifo_wr_rdy,
    input  logic              xfer_start,
    input  logic              xfer_done,
    input  logic              tx_collide_det,
    input  logic              stat_wr_en,
    input  logic [STAT_W-1:0] stat_wr_data,
    output logic              data_irq,
    output logic              err_irq,
    output logic [STAT_W-1:0] status
);
    stat_t set_vec;
    stat_t stat_next;

    spi_err_detect u_det (
        .port_en        (port_en),
        .is_master      (is_master),
        .mode_fault_det (mode_fault_det),
        .xfer_start     (xfer_start),
        .tx_buf_empty   (tx_buf_empty),
        .xfer_done      (xfer_done),
        .rx_buf_full    (rx_buf_full),
        .tx_collide_det (tx_collide_det),
        .set_vec        (set_vec)
    );

    spi_stat_regs u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_vec  (set_vec),
        .wr_en    (stat_wr_en),
        .wr_data  (stat_wr_data),
        .stat_d_o (stat_next),
        .stat_q_o (status)
    );

    spi_irq_route u_route (
        .clk          (clk),
        .rst_n        (rst_n),
        .port_en      (port_en),
        .xfer_mode    (xfer_mode),
        .tx_buf_empty (tx_buf_empty),
        .rx_buf_full  (rx_buf_full),
        .fifo_rd_rdy  (dma_fifo_rd_rdy),
        .fifo_wr_rdy  (dma_fifo_wr_rdy),
        .stat_next    (stat_next),
        .data_irq     (data_irq),
        .err_irq      (err_irq)
    );
endmodule

// File: rtl/spi_irq_status_chk.sv
module spi_irq_status_chk
    import spi_irq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              port_en,
    input logic              is_master,
    input logic [MODE_W-1:0] xfer_mode,
    input logic              rx_buf_full,
    input logic              stat_wr_en,
    input logic [STAT_W-1:0] stat_wr_data,
    input logic              data_irq,
    input logic              err_irq,
    input logic [STAT_W-1:0] status
);
    a_r3_data_off: assert property (@(posedge clk) disable iff (!rst_n)
        !port_en |=> !data_irq);

    a_r2_core_rx_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (port_en && xfer_mode == 2'b00) |=> (data_irq == $past(rx_buf_full)));

    a_r5_fault_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        ((!is_master || !port_en) && !status[ST_FAULT]) |=> !status[ST_FAULT]);

    a_r7_core_err_fault_only: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_mode[1] |=> (err_irq == status[ST_FAULT]));

    a_r8_coll_no_err: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 4'b1000) |-> !err_irq);

    a_r10_err_needs_bit: assert property (@(posedge clk) disable iff (!rst_n)
        err_irq |-> (|status[ST_OVER:ST_FAULT]));

    for (genvar gi = 0; gi < STAT_W; gi++) begin : g_hold
        a_r9_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (status[gi] && !(stat_wr_en && stat_wr_data[gi])) |=> status[gi]);
    end
endmodule

bind spi_irq_status_gen spi_irq_status_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .port_en      (port_en),
    .is_master    (is_master),
    .xfer_mode    (xfer_mode),
    .rx_buf_full  (rx_buf_full),
    .stat_wr_en   (stat_wr_en),
    .stat_wr_data (stat_wr_data),
    .data_irq     (data_irq),
    .err_irq      (err_irq),
    .status       (status)
);

// File: tb/sim_spi_irq_status_gen.sv
module sim_spi_irq_status_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       port_en = 0, is_master = 0, mode_fault_det = 0;
    logic [1:0] xfer_mode = 2'b00;
    logic       tx_buf_empty = 0, rx_buf_full = 0;
    logic       dma_fifo_rd_rdy = 0, dma_fifo_wr_rdy = 0;
    logic       xfer_start = 0, xfer_done = 0, tx_collide_det = 0;
    logic       stat_wr_en = 0;
    logic [3:0] stat_wr_data = '0;
    logic       data_irq, err_irq;
    logic [3:0] status;

    int errors = 0;
    int checks = 0;
    bit finished = 0;
    logic [3:0] mstat = '0;

    typedef struct {
        logic       d;
        logic       e;
        logic [3:0] s;
        string      tag;
    } exp_t;
    exp_t sb[$];

    always #4 clk = ~clk;

    spi_irq_status_gen u0 (
        .clk(clk), .rst_n(rst_n), .port_en(port_en), .is_master(is_master),
        .xfer_mode(xfer_mode), .mode_fault_det(mode_fault_det),
        .tx_buf_empty(tx_buf_empty), .rx_buf_full(rx_buf_full),
        .dma_fifo_rd_rdy(dma_fifo_rd_rdy), .dma_fifo_wr_rdy(dma_fifo_wr_rdy),
        .xfer_start(xfer_start), .xfer_done(xfer_done),
        .tx_collide_det(tx_collide_det), .stat_wr_en(stat_wr_en),
        .stat_wr_data(stat_wr_data), .data_irq(data_irq), .err_irq(err_irq),
        .status(status)
    );

    // driver: inputs are already set (at a negedge); model, push, advance
    task automatic cyc(input string tag);
        exp_t       it;
        logic [3:0] clr, setv, nxt;
        logic       sel;
        setv[0] = port_en & is_master & mode_fault_det;
        setv[1] = port_en & xfer_start & tx_buf_empty;
        setv[2] = port_en & xfer_done & rx_buf_full;
        setv[3] = port_en & tx_collide_det;
        clr = stat_wr_en ? stat_wr_data : 4'b0000;
        nxt = (mstat & ~clr) | setv;
        case (xfer_mode)
            2'b00:   sel = rx_buf_full;
            2'b01:   sel = tx_buf_empty;
            2'b10:   sel = dma_fifo_rd_rdy;
            default: sel = dma_fifo_wr_rdy;
        endcase
        it.d = port_en & sel;
        it.e = nxt[0] | ((xfer_mode == 2'b11) & nxt[1]) | ((xfer_mode == 2'b10) & nxt[2]);
        it.s = nxt;
        it.tag = tag;
        sb.push_back(it);
        mstat = nxt;
        @(negedge clk);
        mode_fault_det = 0; xfer_start = 0; xfer_done = 0;
        tx_collide_det = 0; stat_wr_en = 0; stat_wr_data = '0;
    endtask

    // monitor
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t it;
                it = sb.pop_front();
                checks++;
                if (data_irq !== it.d || err_irq !== it.e || status !== it.s) begin
                    errors++;
                    $display("FAIL %s: act data=%b err=%b stat=%b exp data=%b err=%b stat=%b",
                             it.tag, data_irq, err_irq, status, it.d, it.e, it.s);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: act running exp done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rx_buf_full = 1; mode_fault_det = 1; tx_collide_det = 1;
        repeat (3) @(negedge clk);
        checks++;
        if (data_irq !== 0 || err_irq !== 0 || status !== 4'b0000) begin
            errors++;
            $display("FAIL R1: act data=%b err=%b stat=%b exp 0 0 0000", data_irq, err_irq, status);
        end
        mode_fault_det = 0; tx_collide_det = 0;
        rst_n = 1;
        cyc("R3 port off core rx");

        port_en = 1; is_master = 1;
        xfer_mode = 2'b00; rx_buf_full = 1; tx_buf_empty = 0; cyc("R2 core rx full");
        rx_buf_full = 0; cyc("R2 core rx empty");
        xfer_mode = 2'b01; tx_buf_empty = 1; cyc("R2 core tx");
        xfer_mode = 2'b10; dma_fifo_rd_rdy = 1; dma_fifo_wr_rdy = 0; cyc("R2 dma rd");
        xfer_mode = 2'b11; cyc("R2 dma wr not ready");
        dma_fifo_wr_rdy = 1; cyc("R2 dma wr ready");
        port_en = 0; cyc("R3 port off dma wr");
        port_en = 1;

        xfer_mode = 2'b01; xfer_start = 1; cyc("R6 R7 underflow core no err");
        stat_wr_en = 1; stat_wr_data = 4'b0000; cyc("R9 zero write keeps");
        stat_wr_en = 1; stat_wr_data = 4'b0010; cyc("R9 clear underflow");

        xfer_mode = 2'b11; xfer_start = 1; cyc("R7 underflow dma wr err");
        cyc("R10 err held");
        xfer_mode = 2'b01; cyc("R7 mode change masks underflow");
        stat_wr_en = 1; stat_wr_data = 4'b0010; cyc("R9 clear");

        xfer_mode = 2'b10; rx_buf_full = 1; xfer_done = 1; cyc("R6 R7 overflow dma rd err");
        xfer_mode = 2'b11; cyc("R7 overflow masked in dma wr");
        xfer_mode = 2'b00; xfer_done = 1; cyc("R6 overflow core no err");
        stat_wr_en = 1; stat_wr_data = 4'b0100; cyc("R9 clear overflow");
        rx_buf_full = 0;

        is_master = 0; mode_fault_det = 1; cyc("R5 slave fault ignored");
        is_master = 1; port_en = 0; mode_fault_det = 1; cyc("R5 disabled fault ignored");
        port_en = 1; mode_fault_det = 1; cyc("R4 fault core err");
        xfer_mode = 2'b10; cyc("R4 R10 fault err held dma");
        mode_fault_det = 1; stat_wr_en = 1; stat_wr_data = 4'b0001; cyc("R9 set wins over clear");
        stat_wr_en = 1; stat_wr_data = 4'b0001; cyc("R9 R10 clear fault err drops");

        tx_collide_det = 1; cyc("R8 collision sets no err");
        xfer_mode = 2'b11; cyc("R8 collision sticky");
        stat_wr_en = 1; stat_wr_data = 4'b1000; cyc("R9 clear collision");

        @(negedge clk);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule